// File: doc/BRIEF.md
# Bidirectional Memory Data Register

This block is the data holding register that sits between a processor's internal data bus and the external system bus. It moves a data word in either direction without the two sides clashing. A direction select chooses where the register takes its input from. In the write direction, a processor-side load strobe captures the internal bus. In the read direction, a memory completion strobe captures the system bus. The completion strobe comes from the memory side, so it is first passed through a two-flop synchronizer.

Each output is modelled as a data word plus a drive-valid flag, and no tristate pads are used. The register drives the internal bus only while its processor-side enable is high. It drives the system bus only while its write-drive enable is high. The two enables are independent, so both may be high at once. An output that is not being driven reads as zero.

Top module: `mem_data_reg`

## Requirements
- R1: While reset is low and after it is released, the register holds zero, and `cpu_dout`, `cpu_dout_vld`, `sys_dout` and `sys_dout_vld` are all 0 while neither enable is high.
- R2: With `dir_read` = 0, a rising edge of `load_cpu` loads `cpu_din` into the register. The load happens at the first clock edge that samples `load_cpu` high, and the new value is visible after that edge.
- R3: With `dir_read` = 1, a rising edge of `mem_done` loads `sys_din` into the register. The load happens at the third clock edge that samples `mem_done` high, after a two-flop synchronizer and an edge detector.
- R4: `load_cpu` has no effect while `dir_read` = 1, and a synchronized `mem_done` edge has no effect while `dir_read` = 0. The direction that counts is the one present at the clock edge where the capture would occur.
- R5: A strobe held high causes only one load. Changes on the selected data input while the strobe stays high do not reach the register.
- R6: `cpu_dout_vld` follows `drive_cpu`. `cpu_dout` shows the register while `drive_cpu` = 1 and shows zero otherwise.
- R7: `sys_dout_vld` follows `drive_sys`. `sys_dout` shows the register while `drive_sys` = 1 and shows zero otherwise.
- R8: `drive_cpu` and `drive_sys` may both be 1 at the same time. Both buses then carry the same register value.
- R9: Between qualified capture edges the register keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dir_read | input | 1 | 1 selects the system bus as the input source, 0 selects the internal bus |
| load_cpu | input | 1 | Processor-side capture strobe, acts on its rising edge |
| mem_done | input | 1 | Memory completion strobe, asynchronous, acts on its rising edge |
| drive_cpu | input | 1 | Enable for driving the internal bus |
| drive_sys | input | 1 | Write-drive enable for the system bus |
| cpu_din | input | W | Internal bus data in |
| cpu_dout | output | W | Internal bus data out |
| cpu_dout_vld | output | 1 | Internal bus drive-valid flag |
| sys_din | input | W | System bus data in |
| sys_dout | output | W | System bus data out |
| sys_dout_vld | output | 1 | System bus drive-valid flag |

## Verification
The hardest case to reach is a completion strobe that is still inside the synchronizer when the direction select drops back to write. The capture must then be dropped, because the direction is judged at the capture edge and not when the strobe arrives. The bench raises `mem_done` with `dir_read` high and clears `dir_read` after two clock edges. It then confirms the register is unchanged, which also checks that the three-edge read latency does not leak a stale capture. Full 256-value sweeps in both directions check the load paths and the latency boundary, reading the register back through both outputs.

// File: rtl/mem_data_reg.sv
module mem_data_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dir_read,
  input  logic         load_cpu,
  input  logic         mem_done,
  input  logic         drive_cpu,
  input  logic         drive_sys,
  input  logic [W-1:0] cpu_din,
  output logic [W-1:0] cpu_dout,
  output logic         cpu_dout_vld,
  input  logic [W-1:0] sys_din,
  output logic [W-1:0] sys_dout,
  output logic         sys_dout_vld
);

  logic [W-1:0] data_q;
  logic         load_q;
  logic [2:0]   done_sync;

  wire cpu_edge = load_cpu & ~load_q;
  wire mem_edge = done_sync[1] & ~done_sync[2];
  wire take_cpu = cpu_edge & ~dir_read;
  wire take_mem = mem_edge & dir_read;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_q    <= 1'b0;
      done_sync <= '0;
    end else begin
      load_q    <= load_cpu;
      done_sync <= {done_sync[1:0], mem_done};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        data_q <= '0;
    else if (take_cpu) data_q <= cpu_din;
    else if (take_mem) data_q <= sys_din;
  end

  assign cpu_dout_vld = drive_cpu;
  assign sys_dout_vld = drive_sys;
  assign cpu_dout     = drive_cpu ? data_q : '0;
  assign sys_dout     = drive_sys ? data_q : '0;

  p_cpu_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_cpu && !load_q && !dir_read) |=> (data_q == $past(cpu_din)));

  p_mem_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_sync[1] && !done_sync[2] && dir_read) |=> (data_q == $past(sys_din)));

  p_dir_block_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dir_read && !(done_sync[1] && !done_sync[2])) |=> $stable(data_q));

  p_single_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_cpu && load_q && !(dir_read && done_sync[1] && !done_sync[2]))
      |=> $stable(data_q));

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_cpu && !done_sync[1]) |=> $stable(data_q));

  p_shared_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (drive_cpu && drive_sys) |-> (cpu_dout == sys_dout));

endmodule

// File: tb/mem_data_reg_tb.sv
module mem_data_reg_tb;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dir_read = 1'b0, load_cpu = 1'b0, mem_done = 1'b0;
  logic drive_cpu = 1'b0, drive_sys = 1'b0;
  logic [W-1:0] cpu_din = '0, sys_din = '0;
  logic [W-1:0] cpu_dout, sys_dout;
  logic cpu_dout_vld, sys_dout_vld;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  mem_data_reg #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .dir_read(dir_read), .load_cpu(load_cpu),
    .mem_done(mem_done), .drive_cpu(drive_cpu), .drive_sys(drive_sys),
    .cpu_din(cpu_din), .cpu_dout(cpu_dout), .cpu_dout_vld(cpu_dout_vld),
    .sys_din(sys_din), .sys_dout(sys_dout), .sys_dout_vld(sys_dout_vld)
  );

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic read_back(input string req, input logic [W-1:0] exp);
    drive_cpu = 1'b1;
    #1;
    chk(req, int'(cpu_dout), int'(exp));
    drive_cpu = 1'b0;
  endtask

  task automatic cpu_pulse(input logic [W-1:0] v);
    @(negedge clk); cpu_din = v; load_cpu = 1'b1;
    step();
  endtask

  task automatic cpu_release();
    @(negedge clk); load_cpu = 1'b0;
    step();
  endtask

  task automatic settle_done();
    @(negedge clk); mem_done = 1'b0;
    repeat (4) step();
  endtask

  logic [W-1:0] last;

  initial begin
    repeat (3) step();
    chk("R1 cpu_dout in reset", int'(cpu_dout), 0);
    chk("R1 flags in reset", int'({cpu_dout_vld, sys_dout_vld}), 0);
    @(negedge clk); rst_n = 1'b1;
    step();
    chk("R1 sys_dout after reset", int'(sys_dout), 0);
    read_back("R1 register zero", '0);

    for (int v = 0; v < 256; v++) begin
      cpu_pulse(W'(v));
      read_back("R2 cpu load sweep", W'(v));
      @(negedge clk); drive_sys = 1'b1; #1;
      chk("R7 sys_dout driven", int'(sys_dout), v);
      chk("R7 sys valid", int'(sys_dout_vld), 1);
      drive_sys = 1'b0; #1;
      chk("R7 sys_dout idle zero", int'(sys_dout), 0);
      chk("R6 cpu idle zero", int'({cpu_dout_vld, cpu_dout}), 0);
      cpu_release();
    end
    last = 8'hFF;

    dir_read = 1'b1;
    for (int v = 0; v < 256; v++) begin
      @(negedge clk); sys_din = W'(v ^ 8'hA5); mem_done = 1'b1;
      step(); step();
      read_back("R3 no load before third edge", last);
      step();
      read_back("R3 mem load sweep", W'(v ^ 8'hA5));
      last = W'(v ^ 8'hA5);
      settle_done();
    end

    cpu_pulse(8'h3C);
    cpu_release();
    read_back("R4 load_cpu ignored in read", last);

    @(negedge clk); dir_read = 1'b0; sys_din = 8'h99; mem_done = 1'b1;
    repeat (4) step();
    read_back("R4 mem_done ignored in write", last);
    settle_done();

    @(negedge clk); dir_read = 1'b1; sys_din = 8'h66; mem_done = 1'b1;
    step(); step();
    @(negedge clk); dir_read = 1'b0;
    step(); step();
    read_back("R4 direction dropped mid-sync", last);
    settle_done();

    cpu_pulse(8'h12);
    read_back("R5 first load", 8'h12);
    @(negedge clk); cpu_din = 8'h34;
    step(); step();
    read_back("R5 held strobe no reload", 8'h12);
    cpu_release();
    read_back("R9 hold after release", 8'h12);

    dir_read = 1'b1;
    @(negedge clk); sys_din = 8'h5A; mem_done = 1'b1;
    repeat (3) step();
    read_back("R5 mem first load", 8'h5A);
    @(negedge clk); sys_din = 8'hC3;
    repeat (3) step();
    read_back("R5 mem held no reload", 8'h5A);
    settle_done();

    @(negedge clk); drive_cpu = 1'b1; drive_sys = 1'b1; #1;
    chk("R8 cpu bus with both", int'(cpu_dout), 8'h5A);
    chk("R8 sys bus with both", int'(sys_dout), 8'h5A);
    chk("R8 both flags", int'({cpu_dout_vld, sys_dout_vld}), 3);
    drive_cpu = 1'b0; drive_sys = 1'b0;
    repeat (5) step();
    read_back("R9 idle hold", 8'h5A);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1000000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule